// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit and Deferred Faults

This block keeps the program order of in-flight instructions for a two-wide out-of-order core. Up to two instructions a cycle are allocated at the tail of a six-slot circular buffer. Each slot records the instruction's PC and destination register. Two completion ports fill in results in any order. A completion may also mark a slot as faulted and attach a cause code. From the head, up to two completed slots a cycle retire onto a two-lane architectural register write port.

A fault does nothing while its slot waits. It acts only when the slot reaches the commit point: either as the head, or as the second candidate after a clean first retirement. At that point the slot writes nothing, and a one-cycle exception pulse carries its PC and cause. In the same cycle the slot and every younger slot are discarded, including younger slots that already hold results. A branch-mispredict input separately discards every slot younger than a named slot. Fault flags held by those discarded slots are never raised.

Top module: `rob_commit_unit`

## Requirements
- R1: The buffer holds 6 slots. `alloc_n` (0, 1 or 2) requests that many slots at the tail. `alloc_idx0` and `alloc_idx1` name the next two slots, in wrapping order 0..5. `alloc_ready` is high only when at least `alloc_n` slots are free. A request made while `alloc_ready` is low changes nothing.
- R2: A completion port writes its result, fault bit and cause into an occupied slot, in any order. A completion aimed at an unoccupied slot is ignored.
- R3: Retirement is strictly in order from the head. When the head slot is incomplete, nothing retires. The second lane retires the next slot only if the first lane retired cleanly and that next slot is complete. At most two slots retire per cycle.
- R4: The write port is registered. A slot that is complete and eligible at the start of a cycle appears on the write port after the following clock edge. Lane 0 (`rf_we0`) always carries the older slot.
- R5: A fault flag on a slot that is not at the commit point has no visible effect. There is no write, no exception and no change to occupancy.
- R6: A faulted slot at the commit point writes nothing. `exc_valid` pulses for exactly one cycle, with `exc_pc` equal to that slot's PC and `exc_cause` equal to its cause. A clean older slot in lane 0 still writes in the same cycle.
- R7: The flush discards the faulted slot and all younger slots, including completed ones. It leaves the buffer empty, and the next allocation starts at the faulted slot's index.
- R8: When several slots carry faults, the exception reports the oldest in program order, whatever the order in which the faults arrived.
- R9: `squash_valid` with a live `squash_idx` keeps that slot and everything older, and discards every younger slot along with its fault flag. Allocation then resumes at `squash_idx`+1. `alloc_ready` is low in the squash cycle.
- R10: In a squash cycle, only slots no younger than `squash_idx` may retire or trap. If an exception is taken in the same cycle as a squash, the exception's flush wins.
- R11: After a synchronous reset the buffer is empty, the write enables and `exc_valid` are low, and `alloc_idx0` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_n | input | 2 | Number of slots requested this cycle (0 to 2) |
| alloc_pc0 | input | 16 | PC of the older new instruction |
| alloc_dst0 | input | 5 | Destination register of the older new instruction |
| alloc_pc1 | input | 16 | PC of the younger new instruction |
| alloc_dst1 | input | 5 | Destination register of the younger new instruction |
| alloc_ready | output | 1 | Request of `alloc_n` slots is accepted this cycle |
| alloc_idx0 | output | 3 | Slot index given to the older new instruction |
| alloc_idx1 | output | 3 | Slot index given to the younger new instruction |
| cpl0_valid | input | 1 | Completion port 0 strobe |
| cpl0_idx | input | 3 | Completion port 0 slot index |
| cpl0_data | input | 16 | Completion port 0 result |
| cpl0_fault | input | 1 | Completion port 0 fault flag |
| cpl0_cause | input | 4 | Completion port 0 fault cause |
| cpl1_valid | input | 1 | Completion port 1 strobe |
| cpl1_idx | input | 3 | Completion port 1 slot index |
| cpl1_data | input | 16 | Completion port 1 result |
| cpl1_fault | input | 1 | Completion port 1 fault flag |
| cpl1_cause | input | 4 | Completion port 1 fault cause |
| squash_valid | input | 1 | Branch mispredict: discard slots younger than `squash_idx` |
| squash_idx | input | 3 | Slot of the mispredicted branch (kept) |
| rf_we0 | output | 1 | Register write enable, older lane |
| rf_dst0 | output | 5 | Register index, older lane |
| rf_data0 | output | 16 | Register data, older lane |
| rf_we1 | output | 1 | Register write enable, younger lane |
| rf_dst1 | output | 5 | Register index, younger lane |
| rf_data1 | output | 16 | Register data, younger lane |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_pc | output | 16 | PC of the faulted slot |
| exc_cause | output | 4 | Cause code of the faulted slot |

## Verification
Two functions can land in one cycle: an exception becoming due at the commit point, and a mispredict squash. The bench completes a clean head and a faulted second slot on the same edge, then drives a squash during the cycle in which that trap is decided. It judges the result at the ports: exactly one write, one exception carrying the second slot's PC, and a next allocation index equal to the faulted slot's index rather than the slot after the branch. A second case squashes at the head while two retirable slots wait, and expects only one write.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_RETIRE = 2'd1,
    SLOT_TRAP   = 2'd2
  } slot_act_e;

  // Advance a ring position by step (step never exceeds depth).
  function automatic int ring_add(input int base, input int step, input int depth);
    int s;
    s = base + step;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // Distance walked forward from 'from' to reach 'to' on the ring.
  function automatic int ring_dist(input int from, input int to, input int depth);
    int d;
    d = to - from;
    if (d < 0) d = d + depth;
    return d;
  endfunction

endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl
  import rob_pkg::*;
#(
  parameter  int DEPTH = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       n_alloc,
  input  logic [1:0]       n_retire,
  input  logic             flush,
  input  logic             squash_ok,
  input  logic [IDX_W-1:0] squash_idx,
  input  logic [CNT_W-1:0] squash_keep,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] occ
);

  logic [IDX_W-1:0] head_nx;

  always_comb head_nx = IDX_W'(ring_add(int'(head), int'(n_retire), DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      head <= head_nx;
      if (flush) begin
        tail <= head_nx;
        occ  <= '0;
      end else if (squash_ok) begin
        tail <= IDX_W'(ring_add(int'(squash_idx), 1, DEPTH));
        occ  <= squash_keep - CNT_W'(n_retire);
      end else begin
        tail <= IDX_W'(ring_add(int'(tail), int'(n_alloc), DEPTH));
        occ  <= occ + CNT_W'(n_alloc) - CNT_W'(n_retire);
      end
    end
  end

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter  int DEPTH   = 6,
  parameter  int PC_W    = 16,
  parameter  int DATA_W  = 16,
  parameter  int DST_W   = 5,
  parameter  int CAUSE_W = 4,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_we0,
  input  logic [IDX_W-1:0]   alloc_idx0,
  input  logic [PC_W-1:0]    alloc_pc0,
  input  logic [DST_W-1:0]   alloc_dst0,
  input  logic               alloc_we1,
  input  logic [IDX_W-1:0]   alloc_idx1,
  input  logic [PC_W-1:0]    alloc_pc1,
  input  logic [DST_W-1:0]   alloc_dst1,
  input  logic               cpl_we0,
  input  logic [IDX_W-1:0]   cpl_idx0,
  input  logic [DATA_W-1:0]  cpl_data0,
  input  logic               cpl_fault0,
  input  logic [CAUSE_W-1:0] cpl_cause0,
  input  logic               cpl_we1,
  input  logic [IDX_W-1:0]   cpl_idx1,
  input  logic [DATA_W-1:0]  cpl_data1,
  input  logic               cpl_fault1,
  input  logic [CAUSE_W-1:0] cpl_cause1,
  input  logic [IDX_W-1:0]   rd_idx0,
  input  logic [IDX_W-1:0]   rd_idx1,
  output logic               rd0_done,
  output logic               rd0_fault,
  output logic [CAUSE_W-1:0] rd0_cause,
  output logic [PC_W-1:0]    rd0_pc,
  output logic [DST_W-1:0]   rd0_dst,
  output logic [DATA_W-1:0]  rd0_data,
  output logic               rd1_done,
  output logic               rd1_fault,
  output logic [CAUSE_W-1:0] rd1_cause,
  output logic [PC_W-1:0]    rd1_pc,
  output logic [DST_W-1:0]   rd1_dst,
  output logic [DATA_W-1:0]  rd1_data
);

  // Payload arrays: written by index, no reset.
  logic [PC_W-1:0]    pc_mem   [DEPTH];
  logic [DST_W-1:0]   dst_mem  [DEPTH];
  logic [DATA_W-1:0]  data_mem [DEPTH];
  logic [CAUSE_W-1:0] cause_mem[DEPTH];

  // Status bits kept in flops so allocation can clear them in one cycle.
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] fault_q;

  always_ff @(posedge clk) begin
    if (alloc_we0) begin
      pc_mem[alloc_idx0]  <= alloc_pc0;
      dst_mem[alloc_idx0] <= alloc_dst0;
    end
    if (alloc_we1) begin
      pc_mem[alloc_idx1]  <= alloc_pc1;
      dst_mem[alloc_idx1] <= alloc_dst1;
    end
    if (cpl_we0) begin
      data_mem[cpl_idx0]  <= cpl_data0;
      cause_mem[cpl_idx0] <= cpl_cause0;
    end
    if (cpl_we1) begin
      data_mem[cpl_idx1]  <= cpl_data1;
      cause_mem[cpl_idx1] <= cpl_cause1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= '0;
      fault_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if ((alloc_we0 && alloc_idx0 == IDX_W'(e)) ||
            (alloc_we1 && alloc_idx1 == IDX_W'(e))) begin
          done_q[e]  <= 1'b0;
          fault_q[e] <= 1'b0;
        end else if (cpl_we0 && cpl_idx0 == IDX_W'(e)) begin
          done_q[e]  <= 1'b1;
          fault_q[e] <= cpl_fault0;
        end else if (cpl_we1 && cpl_idx1 == IDX_W'(e)) begin
          done_q[e]  <= 1'b1;
          fault_q[e] <= cpl_fault1;
        end
      end
    end
  end

  assign rd0_done  = done_q[rd_idx0];
  assign rd0_fault = fault_q[rd_idx0];
  assign rd0_cause = cause_mem[rd_idx0];
  assign rd0_pc    = pc_mem[rd_idx0];
  assign rd0_dst   = dst_mem[rd_idx0];
  assign rd0_data  = data_mem[rd_idx0];
  assign rd1_done  = done_q[rd_idx1];
  assign rd1_fault = fault_q[rd_idx1];
  assign rd1_cause = cause_mem[rd_idx1];
  assign rd1_pc    = pc_mem[rd_idx1];
  assign rd1_dst   = dst_mem[rd_idx1];
  assign rd1_data  = data_mem[rd_idx1];

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
  import rob_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] limit,
  input  logic             rd0_done,
  input  logic             rd0_fault,
  input  logic             rd1_done,
  input  logic             rd1_fault,
  output slot_act_e        act0,
  output slot_act_e        act1,
  output logic [1:0]       n_retire,
  output logic             trap
);

  always_comb begin
    act0 = SLOT_IDLE;
    act1 = SLOT_IDLE;
    if (limit >= CNT_W'(1) && rd0_done)
      act0 = rd0_fault ? SLOT_TRAP : SLOT_RETIRE;
    if (act0 == SLOT_RETIRE && limit >= CNT_W'(2) && rd1_done)
      act1 = rd1_fault ? SLOT_TRAP : SLOT_RETIRE;
    n_retire = {1'b0, act0 == SLOT_RETIRE} + {1'b0, act1 == SLOT_RETIRE};
    trap     = (act0 == SLOT_TRAP) || (act1 == SLOT_TRAP);
  end

endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit
  import rob_pkg::*;
#(
  parameter  int DEPTH   = 6,
  parameter  int PC_W    = 16,
  parameter  int DATA_W  = 16,
  parameter  int DST_W   = 5,
  parameter  int CAUSE_W = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         alloc_n,
  input  logic [PC_W-1:0]    alloc_pc0,
  input  logic [DST_W-1:0]   alloc_dst0,
  input  logic [PC_W-1:0]    alloc_pc1,
  input  logic [DST_W-1:0]   alloc_dst1,
  output logic               alloc_ready,
  output logic [IDX_W-1:0]   alloc_idx0,
  output logic [IDX_W-1:0]   alloc_idx1,
  input  logic               cpl0_valid,
  input  logic [IDX_W-1:0]   cpl0_idx,
  input  logic [DATA_W-1:0]  cpl0_data,
  input  logic               cpl0_fault,
  input  logic [CAUSE_W-1:0] cpl0_cause,
  input  logic               cpl1_valid,
  input  logic [IDX_W-1:0]   cpl1_idx,
  input  logic [DATA_W-1:0]  cpl1_data,
  input  logic               cpl1_fault,
  input  logic [CAUSE_W-1:0] cpl1_cause,
  input  logic               squash_valid,
  input  logic [IDX_W-1:0]   squash_idx,
  output logic               rf_we0,
  output logic [DST_W-1:0]   rf_dst0,
  output logic [DATA_W-1:0]  rf_data0,
  output logic               rf_we1,
  output logic [DST_W-1:0]   rf_dst1,
  output logic [DATA_W-1:0]  rf_data1,
  output logic               exc_valid,
  output logic [PC_W-1:0]    exc_pc,
  output logic [CAUSE_W-1:0] exc_cause
);

  logic [IDX_W-1:0]   head_q, tail_q, head_p1;
  logic [CNT_W-1:0]   occ_q;
  logic [1:0]         n_alloc, n_retire;
  logic               trap, squash_ok, alloc_fits;
  logic               cpl_we0, cpl_we1;
  logic [CNT_W-1:0]   sq_age, squash_keep, limit;
  slot_act_e          act0, act1;
  logic               rd0_done, rd0_fault, rd1_done, rd1_fault;
  logic [CAUSE_W-1:0] rd0_cause, rd1_cause;
  logic [PC_W-1:0]    rd0_pc, rd1_pc;
  logic [DST_W-1:0]   rd0_dst, rd1_dst;
  logic [DATA_W-1:0]  rd0_data, rd1_data;

  // Position of a slot counted from the head (0 = oldest).
  function automatic logic [CNT_W-1:0] slot_age(input logic [IDX_W-1:0] idx);
    return CNT_W'(ring_dist(int'(head_q), int'(idx), DEPTH));
  endfunction

  function automatic logic slot_live(input logic [IDX_W-1:0] idx);
    return (int'(idx) < DEPTH) && (slot_age(idx) < occ_q);
  endfunction

  assign head_p1    = IDX_W'(ring_add(int'(head_q), 1, DEPTH));
  assign alloc_idx0 = tail_q;
  assign alloc_idx1 = IDX_W'(ring_add(int'(tail_q), 1, DEPTH));

  always_comb begin
    cpl_we0     = cpl0_valid && slot_live(cpl0_idx);
    cpl_we1     = cpl1_valid && slot_live(cpl1_idx);
    sq_age      = slot_age(squash_idx);
    squash_ok   = squash_valid && slot_live(squash_idx);
    squash_keep = sq_age + CNT_W'(1);
    limit       = squash_ok ? squash_keep : occ_q;
    alloc_fits  = (int'(alloc_n) <= 2) && (int'(alloc_n) <= DEPTH - int'(occ_q));
    alloc_ready = alloc_fits && !trap && !squash_valid;
    n_alloc     = alloc_ready ? alloc_n : 2'd0;
  end

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .n_alloc    (n_alloc),
    .n_retire   (n_retire),
    .flush      (trap),
    .squash_ok  (squash_ok),
    .squash_idx (squash_idx),
    .squash_keep(squash_keep),
    .head       (head_q),
    .tail       (tail_q),
    .occ        (occ_q)
  );

  rob_entry_store #(
    .DEPTH(DEPTH), .PC_W(PC_W), .DATA_W(DATA_W), .DST_W(DST_W), .CAUSE_W(CAUSE_W)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .alloc_we0  (n_alloc != 2'd0),
    .alloc_idx0 (alloc_idx0),
    .alloc_pc0  (alloc_pc0),
    .alloc_dst0 (alloc_dst0),
    .alloc_we1  (n_alloc == 2'd2),
    .alloc_idx1 (alloc_idx1),
    .alloc_pc1  (alloc_pc1),
    .alloc_dst1 (alloc_dst1),
    .cpl_we0    (cpl_we0),
    .cpl_idx0   (cpl0_idx),
    .cpl_data0  (cpl0_data),
    .cpl_fault0 (cpl0_fault),
    .cpl_cause0 (cpl0_cause),
    .cpl_we1    (cpl_we1),
    .cpl_idx1   (cpl1_idx),
    .cpl_data1  (cpl1_data),
    .cpl_fault1 (cpl1_fault),
    .cpl_cause1 (cpl1_cause),
    .rd_idx0    (head_q),
    .rd_idx1    (head_p1),
    .rd0_done   (rd0_done),
    .rd0_fault  (rd0_fault),
    .rd0_cause  (rd0_cause),
    .rd0_pc     (rd0_pc),
    .rd0_dst    (rd0_dst),
    .rd0_data   (rd0_data),
    .rd1_done   (rd1_done),
    .rd1_fault  (rd1_fault),
    .rd1_cause  (rd1_cause),
    .rd1_pc     (rd1_pc),
    .rd1_dst    (rd1_dst),
    .rd1_data   (rd1_data)
  );

  rob_retire_sel #(.CNT_W(CNT_W)) u_sel (
    .limit    (limit),
    .rd0_done (rd0_done),
    .rd0_fault(rd0_fault),
    .rd1_done (rd1_done),
    .rd1_fault(rd1_fault),
    .act0     (act0),
    .act1     (act1),
    .n_retire (n_retire),
    .trap     (trap)
  );

  // Registered outputs toward the register file and the trap logic.
  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we0    <= 1'b0;
      rf_we1    <= 1'b0;
      exc_valid <= 1'b0;
    end else begin
      rf_we0    <= (act0 == SLOT_RETIRE);
      rf_we1    <= (act1 == SLOT_RETIRE);
      exc_valid <= trap;
    end
  end

  always_ff @(posedge clk) begin
    rf_dst0   <= rd0_dst;
    rf_data0  <= rd0_data;
    rf_dst1   <= rd1_dst;
    rf_data1  <= rd1_data;
    exc_pc    <= (act0 == SLOT_TRAP) ? rd0_pc : rd1_pc;
    exc_cause <= (act0 == SLOT_TRAP) ? rd0_cause : rd1_cause;
  end

endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
  parameter  int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] occ,
  input logic             rf_we0,
  input logic             rf_we1,
  input logic             exc_valid
);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH); // R1

  AST_OCC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> int'(occ) <= int'($past(occ)) + 2); // R1

  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
    rf_we1 |-> rf_we0); // R3

  AST_TRAP_NO_LATE_WRITE: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> !rf_we1); // R6

  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !exc_valid); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> occ == '0); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (occ == '0 && !rf_we0 && !rf_we1 && !exc_valid)); // R11

endmodule

bind rob_commit_unit rob_commit_chk #(.DEPTH(DEPTH)) u_rob_chk (
  .clk      (clk),
  .rst      (rst),
  .occ      (occ_q),
  .rf_we0   (rf_we0),
  .rf_we1   (rf_we1),
  .exc_valid(exc_valid)
);

// File: tb/test_rob_commit_unit.sv
`timescale 1ns/1ps
module test_rob_commit_unit;

  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  alloc_n = '0;
  logic [15:0] alloc_pc0 = '0, alloc_pc1 = '0;
  logic [4:0]  alloc_dst0 = '0, alloc_dst1 = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_idx0, alloc_idx1;
  logic        cpl0_valid = 1'b0, cpl1_valid = 1'b0;
  logic [2:0]  cpl0_idx = '0, cpl1_idx = '0;
  logic [15:0] cpl0_data = '0, cpl1_data = '0;
  logic        cpl0_fault = 1'b0, cpl1_fault = 1'b0;
  logic [3:0]  cpl0_cause = '0, cpl1_cause = '0;
  logic        squash_valid = 1'b0;
  logic [2:0]  squash_idx = '0;
  logic        rf_we0, rf_we1, exc_valid;
  logic [4:0]  rf_dst0, rf_dst1;
  logic [15:0] rf_data0, rf_data1, exc_pc;
  logic [3:0]  exc_cause;

  rob_commit_unit i_rob_commit_unit (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Write/exception log gathered away from the active edge.
  int          wr_cnt = 0, exc_cnt = 0;
  logic [4:0]  log_dst [32];
  logic [15:0] log_data[32];
  logic [15:0] last_exc_pc;
  logic [3:0]  last_exc_cause;

  always @(negedge clk) begin
    if (!rst) begin
      if (rf_we0 && wr_cnt < 32) begin
        log_dst[wr_cnt] = rf_dst0; log_data[wr_cnt] = rf_data0; wr_cnt++;
      end
      if (rf_we1 && wr_cnt < 32) begin
        log_dst[wr_cnt] = rf_dst1; log_data[wr_cnt] = rf_data1; wr_cnt++;
      end
      if (exc_valid) begin
        exc_cnt++; last_exc_pc = exc_pc; last_exc_cause = exc_cause;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_cnt = 0; exc_cnt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; alloc_n = '0; cpl0_valid = 0; cpl1_valid = 0; squash_valid = 0;
    idle(2);
    rst = 1'b0;
    clear_log();
  endtask

  task automatic alloc1(input int pc, input int dst);
    alloc_n = 2'd1; alloc_pc0 = 16'(pc); alloc_dst0 = 5'(dst);
    @(negedge clk);
    alloc_n = '0;
  endtask

  task automatic alloc2(input int pc0, input int dst0, input int pc1, input int dst1,
                        output int i0, output int i1);
    alloc_n = 2'd2;
    alloc_pc0 = 16'(pc0); alloc_dst0 = 5'(dst0);
    alloc_pc1 = 16'(pc1); alloc_dst1 = 5'(dst1);
    i0 = int'(alloc_idx0); i1 = int'(alloc_idx1);
    @(negedge clk);
    alloc_n = '0;
  endtask

  task automatic cpl(input int port, input int idx, input int data, input bit f, input int cause);
    if (port == 0) begin
      cpl0_valid = 1; cpl0_idx = 3'(idx); cpl0_data = 16'(data); cpl0_fault = f; cpl0_cause = 4'(cause);
    end else begin
      cpl1_valid = 1; cpl1_idx = 3'(idx); cpl1_data = 16'(data); cpl1_fault = f; cpl1_cause = 4'(cause);
    end
    @(negedge clk);
    cpl0_valid = 0; cpl1_valid = 0;
  endtask

  task automatic cpl2(input int idx0, input int d0, input bit f0, input int c0,
                      input int idx1, input int d1, input bit f1, input int c1);
    cpl0_valid = 1; cpl0_idx = 3'(idx0); cpl0_data = 16'(d0); cpl0_fault = f0; cpl0_cause = 4'(c0);
    cpl1_valid = 1; cpl1_idx = 3'(idx1); cpl1_data = 16'(d1); cpl1_fault = f1; cpl1_cause = 4'(c1);
    @(negedge clk);
    cpl0_valid = 0; cpl1_valid = 0;
  endtask

  task automatic probe_ready(input int n, input int exp, input string tag);
    alloc_n = 2'(n);
    #1;
    chk(tag, int'(alloc_ready), exp);
    alloc_n = '0;
  endtask

  // Fill six slots starting at head 'off', complete them with a fault at
  // position fpos (6 = none) plus a younger fault two places later.
  task automatic sweep_case(input int off, input int fpos, input bit rev);
    int i0, i1, idx, p;
    string tg;
    do_reset();
    for (int k = 0; k < off; k++) begin
      alloc1(0, 0);
      cpl(0, k, 0, 0, 0);
    end
    idle(4);
    clear_log();
    for (int j = 0; j < 3; j++) begin
      alloc2(100 + 2*j, 2*j + 1, 101 + 2*j, 2*j + 2, i0, i1);
      chk($sformatf("R1 alloc index off=%0d j=%0d", off, j), i0, (off + 2*j) % DEPTH);
      chk($sformatf("R1 alloc index+1 off=%0d j=%0d", off, j), i1, (off + 2*j + 1) % DEPTH);
    end
    for (int s = 0; s < 6; s++) begin
      p = rev ? 5 - s : s;
      idx = (off + p) % DEPTH;
      if (p == fpos)
        cpl(s % 2, idx, 16'hA000 + off*16 + p, 1, p + 1);
      else if (fpos < 6 && p == fpos + 2)
        cpl(s % 2, idx, 16'hA000 + off*16 + p, 1, 15);
      else
        cpl(s % 2, idx, 16'hA000 + off*16 + p, 0, 0);
    end
    idle(8);
    tg = $sformatf("off=%0d fault=%0d rev=%0d", off, fpos, rev);
    chk({"R3 R7 write count ", tg}, wr_cnt, fpos);
    for (int w = 0; w < fpos && w < wr_cnt; w++) begin
      chk({"R3 write dst order ", tg}, int'(log_dst[w]), w + 1);
      chk({"R7 write data ", tg}, int'(log_data[w]), 16'hA000 + off*16 + w);
    end
    chk({"R5 R6 exception count ", tg}, exc_cnt, (fpos < 6) ? 1 : 0);
    if (fpos < 6 && exc_cnt > 0) begin
      chk({"R6 exception pc ", tg}, int'(last_exc_pc), 100 + fpos);
      chk({"R8 oldest cause ", tg}, int'(last_exc_cause), fpos + 1);
    end
    chk({"R7 restart index ", tg}, int'(alloc_idx0), (off + fpos) % DEPTH);
    probe_ready(2, 1, {"R7 empty after drain ", tg});
  endtask

  initial begin
    int a, b;
    idle(1);
    do_reset();

    // R11 reset state
    chk("R11 rf_we0 after reset", int'(rf_we0), 0);
    chk("R11 exc_valid after reset", int'(exc_valid), 0);
    chk("R11 alloc_idx0 after reset", int'(alloc_idx0), 0);
    probe_ready(2, 1, "R11 ready when empty");

    // R3 / R4: head incomplete blocks; both lanes go on the second edge
    alloc2(10, 3, 11, 4, a, b);
    cpl(1, 1, 16'h0111, 0, 0);
    idle(3);
    chk("R3 no retire with head incomplete", wr_cnt, 0);
    cpl(0, 0, 16'h0100, 0, 0);
    chk("R4 not yet written after one edge", int'(rf_we0), 0);
    @(negedge clk);
    chk("R4 lane0 write after two edges", int'(rf_we0), 1);
    chk("R3 lane1 same cycle", int'(rf_we1), 1);
    chk("R4 lane0 carries older dst", int'(rf_dst0), 3);
    chk("R4 lane1 dst", int'(rf_dst1), 4);

    // R1 stall
    do_reset();
    for (int j = 0; j < 3; j++) alloc2(20 + j, 1, 30 + j, 2, a, b);
    probe_ready(1, 0, "R1 full refuses one");
    alloc_n = 2'd1; @(negedge clk); alloc_n = '0;
    chk("R1 refused request leaves tail", int'(alloc_idx0), 0);
    cpl(0, 0, 0, 0, 0);
    idle(3);
    probe_ready(2, 0, "R1 one free refuses two");
    probe_ready(1, 1, "R1 one free accepts one");

    // R2 completion to unoccupied slot ignored
    do_reset();
    alloc1(40, 7);
    cpl(1, 3, 16'h0BAD, 1, 5);
    cpl(0, 0, 16'h0040, 0, 0);
    idle(4);
    chk("R2 stray completion no exception", exc_cnt, 0);
    chk("R2 live slot retired", wr_cnt, 1);
    chk("R2 tail untouched", int'(alloc_idx0), 1);

    // R5 flag is silent until commit point
    do_reset();
    alloc2(50, 1, 51, 2, a, b);
    cpl(1, 1, 0, 1, 6);
    idle(4);
    chk("R5 waiting fault no exception", exc_cnt, 0);
    chk("R5 waiting fault no write", wr_cnt, 0);
    chk("R5 waiting fault keeps occupancy", int'(alloc_idx0), 2);
    cpl(0, 0, 16'h0050, 0, 0);
    idle(3);
    chk("R6 clean lane0 written with trap", wr_cnt, 1);
    chk("R6 trap pc from lane1", int'(last_exc_pc), 51);
    chk("R6 trap cause", int'(last_exc_cause), 6);

    // R9 squash discards younger slots and their faults
    do_reset();
    for (int j = 0; j < 3; j++) alloc2(200 + 2*j, 1, 201 + 2*j, 2, a, b);
    cpl2(4, 0, 1, 3, 3, 16'h0033, 0, 0);
    idle(2);
    squash_valid = 1; squash_idx = 3'd2;
    probe_ready(1, 0, "R9 no allocation in squash cycle");
    @(negedge clk);
    squash_valid = 0;
    chk("R9 tail after squash", int'(alloc_idx0), 3);
    cpl2(0, 1, 0, 0, 1, 2, 0, 0);
    cpl(0, 2, 3, 0, 0);
    idle(5);
    chk("R9 only kept slots retire", wr_cnt, 3);
    chk("R9 squashed fault never raised", exc_cnt, 0);

    // R10 squash at head limits retirement to one slot
    do_reset();
    alloc2(60, 1, 61, 2, a, b);
    cpl2(0, 16'h0600, 0, 0, 1, 16'h0601, 0, 0);
    squash_valid = 1; squash_idx = 3'd0;
    @(negedge clk);
    squash_valid = 0;
    idle(3);
    chk("R10 squash at head retires one", wr_cnt, 1);
    chk("R10 tail after head squash", int'(alloc_idx0), 1);

    // R10 exception and squash decided in the same cycle
    do_reset();
    alloc2(70, 1, 71, 2, a, b);
    alloc2(72, 3, 73, 4, a, b);
    cpl2(0, 16'h0700, 0, 0, 1, 16'h0701, 1, 9);
    squash_valid = 1; squash_idx = 3'd2;
    @(negedge clk);
    squash_valid = 0;
    idle(3);
    chk("R10 one write before trap", wr_cnt, 1);
    chk("R10 exception taken", exc_cnt, 1);
    chk("R10 exception pc", int'(last_exc_pc), 71);
    chk("R10 flush wins over squash", int'(alloc_idx0), 1);

    // Sweep: every head offset, every fault position, two completion orders
    for (int off = 0; off < DEPTH; off++)
      for (int f = 0; f <= DEPTH; f++)
        for (int r = 0; r < 2; r++)
          sweep_case(off, f, r[0]);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule